// File: doc/BRIEF.md
# Multi-chain parallel scan self-test engine

This block runs a logic self-test on a small sample circuit whose flip-flops form three scan chains of unequal length. One pseudorandom generator supplies the serial input of every chain at once, with a different generator bit for each chain. A multiple-input signature register takes the serial output of every chain at once and folds them into one signature. Each pattern is shifted in for K cycles, where K is the length of the longest chain, and then the chains take one functional capture cycle. After the last capture, one more K-cycle shift unloads the final response.

Software or a test sequencer pulses `start` with a pattern count. When the run ends, the engine raises `done`, presents the signature and sets `pass` if the signature equals a golden value given as a parameter. The results stay put until the next start. Bits that spill out of the shorter chains during the long shift are compressed like any other bit. Because every compressed bit comes from fixed seeds and the applied patterns, the signature depends only on the pattern count.

Top module: `mcb_bist_top`

## Requirements
- R1: After reset `done` and `pass` are 0 and `signature` shows the signature seed 16'h1D0F.
- R2: A `start` pulse seen while the engine is idle begins a run, latches `pat_count`, and clears `done` and `pass` on the next clock edge.
- R3: The generator is 16 bits wide and is loaded with 16'hACE1 at start. On each shift cycle it steps to {p[14:0], ^(p & 16'hB400)}, and chain i takes generator bit p[i] as its serial input before the step.
- R4: The chains have lengths 5, 3 and 7 and form a flat state vector S[14:0]: chain 0 is S[4:0], chain 1 is S[7:5] and chain 2 is S[14:8]. A shift puts the serial input into the lowest bit of a chain, and the chain's serial output is its highest bit.
- R5: Each pattern is shifted in for K = 7 cycles and then captured in one cycle with shift disabled. The capture loads D[j] = S[(j+14) mod 15] ^ (S[j] & S[(j+1) mod 15]) into every bit.
- R6: The signature register is loaded with 16'h1D0F at start. On every shift cycle except those of the first load, it becomes {m[14:0], ^(m & 16'hB400)} XOR the chain outputs, with chain i on bit i. It holds its value in every other cycle.
- R7: After the last capture the engine shifts K more cycles to unload. `done` rises (N+1)*K + N + 1 clock edges after the edge that sampled `start`, where N is the pattern count.
- R8: `pass` is set together with `done` and is 1 exactly when `signature` equals the GOLDEN parameter.
- R9: `done`, `pass` and `signature` hold their values until the next `start`.
- R10: A `start` pulse during a run is ignored. The run ends with the latency and signature of its original pattern count.
- R11: A pattern count of 0 performs only the load shift. `done` rises K+1 edges after start, and `signature` equals the seed 16'h1D0F.
- R12: The signature for a given pattern count does not depend on what the chains held before the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that begins a run while idle |
| pat_count | input | 16 | Number of patterns, sampled at start |
| done | output | 1 | Run finished, held until next start |
| pass | output | 1 | Signature equals GOLDEN, valid with done |
| signature | output | 16 | Signature register contents |

## Verification
The assertions assume that `start` is a single-cycle pulse driven by the surrounding logic. They also assume that `pat_count` is stable at the sampling edge, and they let a `start` that arrives mid-run stay legal but without effect. The stimulus drives `start` for exactly one cycle away from the clock edge in each run. It fires one extra mid-run pulse with a different count to exercise that tolerance. Pattern counts stay small, so every run ends well inside the latency bound the controller assertions track.

// File: rtl/mcb_pkg.sv
package mcb_pkg;

    localparam int unsigned NCH       = 3;
    localparam int unsigned GW        = 16;
    localparam int unsigned SW        = 16;
    localparam int unsigned PCW       = 16;
    localparam logic [GW-1:0] GEN_TAPS = 16'hB400;
    localparam logic [GW-1:0] GEN_SEED = 16'hACE1;
    localparam logic [SW-1:0] SIG_TAPS = 16'hB400;
    localparam logic [SW-1:0] SIG_SEED = 16'h1D0F;

    function automatic int unsigned chain_len(int i);
        case (i)
            0:       return 5;
            1:       return 3;
            default: return 7;
        endcase
    endfunction

    function automatic int unsigned chain_off(int i);
        int unsigned acc = 0;
        for (int k = 0; k < i; k++) acc += chain_len(k);
        return acc;
    endfunction

    function automatic int unsigned longest_chain();
        int unsigned mx = 0;
        for (int k = 0; k < int'(NCH); k++)
            if (chain_len(k) > mx) mx = chain_len(k);
        return mx;
    endfunction

    localparam int unsigned KLEN  = longest_chain();
    localparam int unsigned TOTAL = chain_off(NCH);
    localparam int unsigned CW    = $clog2(KLEN + 1);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_CAPT  = 2'd2,
        ST_FIN   = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic reseed;
        logic shift;
        logic capture;
        logic compress;
    } scan_ctl_t;

    // Sample logic under test: next state of every scan cell
    function automatic logic [TOTAL-1:0] cut_logic(logic [TOTAL-1:0] s);
        logic [TOTAL-1:0] d;
        for (int j = 0; j < int'(TOTAL); j++)
            d[j] = s[(j + int'(TOTAL) - 1) % int'(TOTAL)]
                 ^ (s[j] & s[(j + 1) % int'(TOTAL)]);
        return d;
    endfunction

endpackage

// File: rtl/mcb_prpg.sv
module mcb_prpg #(
    parameter int unsigned W    = 16,
    parameter int unsigned NOUT = 3,
    parameter logic [W-1:0] TAPS = 16'hB400,
    parameter logic [W-1:0] SEED = 16'hACE1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            reseed,
    input  logic            step,
    output logic [NOUT-1:0] bits_out
);

    logic [W-1:0] state;

    always_ff @(posedge clk) begin
        if (rst || reseed)
            state <= SEED;
        else if (step)
            state <= {state[W-2:0], ^(state & TAPS)};
    end

    assign bits_out = state[NOUT-1:0];

    // R3: a nonzero seed never reaches the all-zero lock state
    a_r3_never_zero: assert property (@(posedge clk) disable iff (rst)
        state != '0);

endmodule

// File: rtl/mcb_misr.sv
module mcb_misr #(
    parameter int unsigned W   = 16,
    parameter int unsigned NIN = 3,
    parameter logic [W-1:0] TAPS = 16'hB400,
    parameter logic [W-1:0] SEED = 16'h1D0F
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           init,
    input  logic           en,
    input  logic [NIN-1:0] din,
    output logic [W-1:0]   sig
);

    logic [W-1:0] folded;

    assign folded = {sig[W-2:0], ^(sig & TAPS)} ^ {{(W-NIN){1'b0}}, din};

    always_ff @(posedge clk) begin
        if (rst || init)
            sig <= SEED;
        else if (en)
            sig <= folded;
    end

endmodule

// File: rtl/mcb_chain.sv
module mcb_chain #(
    parameter int unsigned L = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         se,
    input  logic         ce,
    input  logic         si,
    input  logic [L-1:0] pin,
    output logic [L-1:0] q,
    output logic         so
);

    generate
        if (L == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst)     q <= '0;
                else if (se) q <= si;
                else if (ce) q <= pin;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst)     q <= '0;
                else if (se) q <= {q[L-2:0], si};
                else if (ce) q <= pin;
            end
        end
    endgenerate

    assign so = q[L-1];

endmodule

// File: rtl/mcb_cut.sv
module mcb_cut
    import mcb_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           se,
    input  logic           ce,
    input  logic [NCH-1:0] si,
    output logic [NCH-1:0] so
);

    logic [TOTAL-1:0] cells;
    logic [TOTAL-1:0] next_cells;

    assign next_cells = cut_logic(cells);

    generate
        for (genvar c = 0; c < int'(NCH); c++) begin : g_chain
            localparam int unsigned L   = chain_len(c);
            localparam int unsigned OFF = chain_off(c);
            mcb_chain #(.L(L)) u_chain (
                .clk (clk),
                .rst (rst),
                .se  (se),
                .ce  (ce),
                .si  (si[c]),
                .pin (next_cells[OFF +: L]),
                .q   (cells[OFF +: L]),
                .so  (so[c])
            );
        end
    endgenerate

    // R5: shift and capture never overlap
    a_r5_shift_capture_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({se, ce}));

endmodule

// File: rtl/mcb_ctrl.sv
module mcb_ctrl
    import mcb_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [PCW-1:0] npat,
    output scan_ctl_t      ctl,
    output logic           finish,
    output logic           busy
);

    seq_state_e     state;
    logic [CW-1:0]  cnt;
    logic [PCW-1:0] caps;
    logic [PCW-1:0] npat_q;
    logic           last_shift;

    assign last_shift = (cnt == CW'(KLEN - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            caps   <= '0;
            npat_q <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state  <= ST_SHIFT;
                        cnt    <= '0;
                        caps   <= '0;
                        npat_q <= npat;
                    end
                end
                ST_SHIFT: begin
                    if (last_shift) begin
                        cnt   <= '0;
                        state <= (caps == npat_q) ? ST_FIN : ST_CAPT;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                ST_CAPT: begin
                    caps  <= caps + PCW'(1);
                    state <= ST_SHIFT;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        ctl.reseed   = (state == ST_IDLE) && start;
        ctl.shift    = (state == ST_SHIFT);
        ctl.capture  = (state == ST_CAPT);
        ctl.compress = (state == ST_SHIFT) && (caps != '0);
    end

    assign finish = (state == ST_FIN);
    assign busy   = (state != ST_IDLE);

    // R5: the shift counter stays within one chain length
    a_r5_count_bound: assert property (@(posedge clk) disable iff (rst)
        cnt < CW'(KLEN));

    // R5: a capture always follows a full K-cycle shift
    a_r5_capture_after_k: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CAPT) |-> ($past(state) == ST_SHIFT && $past(cnt) == CW'(KLEN - 1)));

    // R7: never more captures than requested patterns
    a_r7_caps_bound: assert property (@(posedge clk) disable iff (rst)
        caps <= npat_q);

    // R2: a start while idle leaves idle on the next edge
    a_r2_start_leaves_idle: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && start) |=> (state == ST_SHIFT));

endmodule

// File: rtl/mcb_bist_top.sv
module mcb_bist_top
    import mcb_pkg::*;
#(
    parameter logic [SW-1:0] GOLDEN = 16'h1D0F
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [PCW-1:0] pat_count,
    output logic           done,
    output logic           pass,
    output logic [SW-1:0]  signature
);

    scan_ctl_t      ctl;
    logic           finish;
    logic           busy;
    logic [NCH-1:0] scan_in;
    logic [NCH-1:0] scan_out;

    mcb_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .npat   (pat_count),
        .ctl    (ctl),
        .finish (finish),
        .busy   (busy)
    );

    mcb_prpg #(.W(GW), .NOUT(NCH), .TAPS(GEN_TAPS), .SEED(GEN_SEED)) u_prpg (
        .clk      (clk),
        .rst      (rst),
        .reseed   (ctl.reseed),
        .step     (ctl.shift),
        .bits_out (scan_in)
    );

    mcb_cut u_cut (
        .clk (clk),
        .rst (rst),
        .se  (ctl.shift),
        .ce  (ctl.capture),
        .si  (scan_in),
        .so  (scan_out)
    );

    mcb_misr #(.W(SW), .NIN(NCH), .TAPS(SIG_TAPS), .SEED(SIG_SEED)) u_misr (
        .clk  (clk),
        .rst  (rst),
        .init (ctl.reseed),
        .en   (ctl.compress),
        .din  (scan_out),
        .sig  (signature)
    );

    always_ff @(posedge clk) begin
        if (rst || ctl.reseed) begin
            done <= 1'b0;
            pass <= 1'b0;
        end else if (finish) begin
            done <= 1'b1;
            pass <= (signature == GOLDEN);
        end
    end

    // R6: the signature does not move across a capture cycle
    a_r6_capture_holds_sig: assert property (@(posedge clk) disable iff (rst)
        ctl.capture |=> $stable(signature));

    // R9: results stay frozen while no new start arrives
    a_r9_results_hold: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(signature) && $stable(pass)));

    // R2: an accepted start drops done
    a_r2_start_clears_done: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> !done);

    // R8: pass only with a matching signature
    a_r8_pass_matches: assert property (@(posedge clk) disable iff (rst)
        pass |-> (done && signature == GOLDEN));

    // R10: done is never raised while a run is in progress
    a_r10_no_done_when_busy: assert property (@(posedge clk) disable iff (rst)
        (busy && !finish) |=> !done);

endmodule

// File: tb/tb_mcb_bist_top.sv
module tb_mcb_bist_top;

    localparam logic [15:0] T_GSEED = 16'hACE1;
    localparam logic [15:0] T_MSEED = 16'h1D0F;
    localparam logic [15:0] T_TAPS  = 16'hB400;
    localparam logic [15:0] T_GOLD  = 16'h1D0F;
    localparam int          T_K     = 7;

    // bit 16: fire an extra start mid-run; bits 15:0: pattern count
    localparam logic [16:0] VEC [7] = '{
        17'h0_0001, 17'h0_0002, 17'h1_0003, 17'h0_0000,
        17'h0_0005, 17'h0_0003, 17'h1_0008
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] pat_count = '0;
    logic        done;
    logic        pass;
    logic [15:0] signature;

    int tests = 0;
    int fails = 0;
    logic [15:0] first3 = '0;
    logic        have3 = 1'b0;

    always #5 clk = ~clk;

    mcb_bist_top #(.GOLDEN(T_GOLD)) dut (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .pat_count (pat_count),
        .done      (done),
        .pass      (pass),
        .signature (signature)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [14:0] cut_model(input logic [14:0] s);
        logic [14:0] d;
        for (int j = 0; j < 15; j++)
            d[j] = s[(j + 14) % 15] ^ (s[j] & s[(j + 1) % 15]);
        return d;
    endfunction

    function automatic logic [15:0] model_sig(input int np);
        logic [15:0] p;
        logic [15:0] m;
        logic [14:0] s;
        logic [14:0] ns;
        logic [2:0]  so;
        p = T_GSEED;
        m = T_MSEED;
        s = '0;
        for (int k = 0; k <= np; k++) begin
            for (int c = 0; c < T_K; c++) begin
                so = {s[14], s[7], s[4]};
                ns[4:0]  = {s[3:0],  p[0]};
                ns[7:5]  = {s[6:5],  p[1]};
                ns[14:8] = {s[13:8], p[2]};
                if (k != 0) m = {m[14:0], ^(m & T_TAPS)} ^ {13'd0, so};
                p = {p[14:0], ^(p & T_TAPS)};
                s = ns;
            end
            if (k < np) s = cut_model(s);
        end
        return m;
    endfunction

    task automatic run_case(input int np, input logic poke);
        int n;
        int exp_lat;
        logic [15:0] exp_sig;
        logic [15:0] held;
        exp_lat = (np + 1) * T_K + np + 1;
        exp_sig = model_sig(np);
        @(negedge clk);
        start = 1'b1;
        pat_count = 16'(np);
        @(posedge clk);
        #1;
        start = 1'b0;
        pat_count = 16'hFFFF;
        chk(done == 1'b0 && pass == 1'b0, "R2 done cleared after start", int'(done), 0);
        n = 0;
        while (n < 5000) begin
            @(posedge clk);
            n++;
            #1;
            start = 1'b0;
            if (done) break;
            if (poke && n == 3) begin
                start = 1'b1;
                pat_count = 16'(np + 4);
            end
        end
        if (np == 0)
            chk(n == exp_lat, "R11 zero-count latency", n, exp_lat);
        else if (poke)
            chk(n == exp_lat, "R10 latency unchanged by mid-run start", n, exp_lat);
        else
            chk(n == exp_lat, "R7 done latency", n, exp_lat);
        chk(signature == exp_sig, "R3 R4 R5 R6 signature", int'(signature), int'(exp_sig));
        chk(pass == (exp_sig == T_GOLD), "R8 pass flag", int'(pass), int'(exp_sig == T_GOLD));
        if (np == 3) begin
            if (have3)
                chk(signature == first3, "R12 repeat run signature", int'(signature), int'(first3));
            else begin
                first3 = signature;
                have3 = 1'b1;
            end
        end
        held = signature;
        repeat (12) @(posedge clk);
        #1;
        chk(done == 1'b1 && signature == held, "R9 results held", int'(signature), int'(held));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        chk(done == 1'b0, "R1 reset done", int'(done), 0);
        chk(pass == 1'b0, "R1 reset pass", int'(pass), 0);
        chk(signature == T_MSEED, "R1 reset signature", int'(signature), int'(T_MSEED));
        for (int i = 0; i < 7; i++)
            run_case(int'(VEC[i][15:0]), VEC[i][16]);
        // directed: zero count after a long run must give the seed
        run_case(0, 1'b0);
        chk(signature == T_MSEED && pass == 1'b1, "R11 seed signature and pass",
            int'(signature), int'(T_MSEED));
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule